// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block takes a clock generator with several gated output clock groups into its low-power state and back out again. The power-down request is active low and may change at any moment. It is resynchronised onto an always-running reference clock before it can change anything.

On entry, the block withdraws the enable of every output group. Each group latches its enable on a falling edge of its own clock, so it stops low and stays low with no shortened pulse. The sequencer waits until every group, including a slow group that needs several of its own periods, reports that it is parked. Only then does it drop the VCO enable, and one reference cycle later the oscillator enable. On release, the steps run in reverse: the oscillator comes up first, then the VCO. A programmable settle interval counted in reference cycles follows, and then the outputs are re-enabled on their own low phases.

Once entry has begun, it always finishes, and once exit has begun, it always finishes. A request that changes in between is acted on afterwards. A status output marks the fully-off state.

Top module: `clkpd_seq`

## Requirements
- R1: `pd_n` reaches the sequencer only through a two-flop synchroniser clocked by `ref_clk`. A low pulse that spans no rising edge of `ref_clk` changes nothing. Entry and exit each begin only from the synchronised request.
- R2: A stopped group output goes low only at a falling edge of its own clock and stays low while stopped. Every high pulse on `grp_out` lasts a full half period of its group clock.
- R3: `vco_en` falls only after every group reports parked, including the slow group on `grp_clk[0]`. At that moment every `grp_out` has been low for at least two `ref_clk` periods. While any group is enabled, `vco_en` and `xtal_en` are both high.
- R4: `xtal_en` falls exactly one `ref_clk` cycle after `vco_en` falls, and never while `vco_en` is high.
- R5: `pd_status` is 1 only in the fully-off state. In that state `vco_en`, `xtal_en` and every `grp_out` are low.
- R6: If the request is released while entry is under way, entry still finishes in the off state (`pd_status` rises), and exit follows on its own.
- R7: On exit, `xtal_en` rises first and `vco_en` rises exactly one `ref_clk` cycle later.
- R8: Outputs are re-enabled no earlier than `SETTLE_CYC` `ref_clk` cycles after `vco_en` rises. The default of 28636 cycles is 2.0 ms at 14.318 MHz, which keeps power-up inside a 3 ms budget.
- R9: While `rst_n` is low, `vco_en` and `xtal_en` are 1, `pd_status` is 0 and every `grp_out` is low. After release, all groups start toggling within a few of their own periods.
- R10: A request that returns during exit lets the exit finish and the outputs restart. A new entry then follows and reaches the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock for the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| grp_clk | input | NUM_GRP | Free-running clock of each output group; bit 0 is the slow reference group |
| grp_out | output | NUM_GRP | Gated output clock of each group |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pd_status | output | 1 | 1 only while fully powered down |

## Verification
The properties assume that `ref_clk` keeps running throughout, and that every group clock keeps toggling until its group has parked. Without that, the parked handshake could never complete. `pd_n` is free to move at any time. The bench moves it either half a reference cycle away from the sampling edge, or as a deliberate sub-cycle pulse between two rising edges to exercise the synchroniser. Group clocks free-run at unrelated periods, one of them much slower than the reference, so each group parks and restarts at its own phase.

// File: rtl/clkpd_pkg.sv
`timescale 1ns/1ps
package clkpd_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_STOP,
    ST_WAIT_PARK,
    ST_VCO_OFF,
    ST_XTAL_OFF,
    ST_OFF,
    ST_XTAL_ON,
    ST_VCO_ON,
    ST_START
  } pd_state_e;

  typedef struct packed {
    logic gate_en;
    logic vco_en;
    logic xtal_en;
    logic off;
  } pd_ctl_t;

  // Control levels that hold while the sequencer sits in a state.
  function automatic pd_ctl_t state_ctl(pd_state_e st);
    pd_ctl_t c;
    c = '{gate_en: 1'b0, vco_en: 1'b1, xtal_en: 1'b1, off: 1'b0};
    case (st)
      ST_RUN, ST_START:   c.gate_en = 1'b1;
      ST_STOP, ST_WAIT_PARK, ST_VCO_ON: c.gate_en = 1'b0;
      ST_VCO_OFF, ST_XTAL_ON: c.vco_en = 1'b0;
      ST_XTAL_OFF: begin
        c.vco_en  = 1'b0;
        c.xtal_en = 1'b0;
      end
      ST_OFF: begin
        c.vco_en  = 1'b0;
        c.xtal_en = 1'b0;
        c.off     = 1'b1;
      end
      default: c.gate_en = 1'b0;
    endcase
    return c;
  endfunction

  // The settle window closes once cnt+1 cycles have elapsed in the VCO-on state.
  function automatic logic settle_done(int unsigned cnt, int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // Reference cycles in a span of microseconds for a clock given in kHz.
  function automatic int unsigned cycles_for_us(int unsigned us, int unsigned fref_khz);
    return (us * fref_khz) / 1000;
  endfunction

endpackage

// File: rtl/clkpd_sync.sv
`timescale 1ns/1ps
module clkpd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/clkpd_gate.sv
`timescale 1ns/1ps
module clkpd_gate (
  input  logic gck,
  input  logic rst_n,
  input  logic en,
  output logic gout,
  output logic parked
);
  logic en_s;
  logic en_fall_q;

  // Bring the enable into this group's own clock domain.
  clkpd_sync #(.W(1), .RST_VAL(1'b0)) u_en_sync (
    .clk  (gck),
    .rst_n(rst_n),
    .d    (en),
    .q    (en_s)
  );

  // Take the enable on the falling edge, so it only changes while gck is low.
  always_ff @(negedge gck or negedge rst_n) begin
    if (!rst_n) en_fall_q <= 1'b0;
    else        en_fall_q <= en_s;
  end

  assign gout   = gck & en_fall_q;
  assign parked = ~en_fall_q;
endmodule

// File: rtl/clkpd_fsm.sv
`timescale 1ns/1ps
module clkpd_fsm
  import clkpd_pkg::*;
#(
  parameter int unsigned NUM_GRP    = 4,
  parameter int unsigned SETTLE_CYC = 28636
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_req,
  input  logic [NUM_GRP-1:0] parked_s,
  output logic               gate_en,
  output logic               vco_en,
  output logic               xtal_en,
  output logic               pd_status
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  pd_state_e st_q, st_nxt;
  logic [CW-1:0] settle_q;
  pd_ctl_t ctl_q;
  logic all_parked, none_parked, settle_end;

  assign all_parked  = &parked_s;
  assign none_parked = ~|parked_s;
  assign settle_end  = settle_done(32'(settle_q), SETTLE_CYC);

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_RUN:       if (pd_req) st_nxt = ST_STOP;
      ST_STOP:      st_nxt = ST_WAIT_PARK;
      ST_WAIT_PARK: if (all_parked) st_nxt = ST_VCO_OFF;
      ST_VCO_OFF:   st_nxt = ST_XTAL_OFF;
      ST_XTAL_OFF:  st_nxt = ST_OFF;
      ST_OFF:       if (!pd_req) st_nxt = ST_XTAL_ON;
      ST_XTAL_ON:   st_nxt = ST_VCO_ON;
      ST_VCO_ON:    if (settle_end) st_nxt = ST_START;
      ST_START:     if (none_parked) st_nxt = ST_RUN;
      default:      st_nxt = ST_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_START;
      ctl_q    <= state_ctl(ST_START);
      settle_q <= '0;
    end else begin
      st_q     <= st_nxt;
      ctl_q    <= state_ctl(st_nxt);
      settle_q <= (st_q == ST_VCO_ON) ? settle_q + 1'b1 : '0;
    end
  end

  assign gate_en   = ctl_q.gate_en;
  assign vco_en    = ctl_q.vco_en;
  assign xtal_en   = ctl_q.xtal_en;
  assign pd_status = ctl_q.off;
endmodule

// File: rtl/clkpd_seq.sv
`timescale 1ns/1ps
module clkpd_seq
  import clkpd_pkg::*;
#(
  parameter int unsigned NUM_GRP    = 4,
  parameter int unsigned SETTLE_CYC = cycles_for_us(2000, 14318)
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic [NUM_GRP-1:0] grp_clk,
  output logic [NUM_GRP-1:0] grp_out,
  output logic               vco_en,
  output logic               xtal_en,
  output logic               pd_status
);
  logic               pd_n_s;
  logic               pd_req;
  logic               gate_en;
  logic [NUM_GRP-1:0] parked_raw;
  logic [NUM_GRP-1:0] parked_s;

  clkpd_sync #(.W(1), .RST_VAL(1'b1)) u_req_sync (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .d    (pd_n),
    .q    (pd_n_s)
  );
  assign pd_req = ~pd_n_s;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    clkpd_gate u_gate (
      .gck   (grp_clk[g]),
      .rst_n (rst_n),
      .en    (gate_en),
      .gout  (grp_out[g]),
      .parked(parked_raw[g])
    );
  end

  clkpd_sync #(.W(NUM_GRP), .RST_VAL({NUM_GRP{1'b1}})) u_park_sync (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .d    (parked_raw),
    .q    (parked_s)
  );

  clkpd_fsm #(.NUM_GRP(NUM_GRP), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .pd_req   (pd_req),
    .parked_s (parked_s),
    .gate_en  (gate_en),
    .vco_en   (vco_en),
    .xtal_en  (xtal_en),
    .pd_status(pd_status)
  );
endmodule

// File: rtl/clkpd_seq_chk.sv
`timescale 1ns/1ps
module clkpd_seq_chk #(
  parameter int unsigned NUM_GRP    = 4,
  parameter int unsigned SETTLE_CYC = 28636
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pd_req,
  input logic               gate_en,
  input logic [NUM_GRP-1:0] parked_s,
  input logic               vco_en,
  input logic               xtal_en,
  input logic               pd_status
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 2);

  logic [CW-1:0] since_vco;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_vco <= '0;
    else if (!vco_en)           since_vco <= '0;
    else if (since_vco != '1)   since_vco <= since_vco + 1'b1;
  end

  // R1
  entry_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> $past(pd_req));

  // R1
  exit_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_en) |-> $past(!pd_req));

  // R3
  vco_after_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> &parked_s);

  // R3
  gate_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> (vco_en && xtal_en));

  // R4
  xtal_after_vco_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xtal_en) |-> ($past(!vco_en) && !vco_en));

  // R5
  status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_status |-> (!vco_en && !xtal_en && !gate_en && (&parked_s)));

  // R7
  vco_on_after_xtal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_en) |-> $past(xtal_en));

  // R8
  settle_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (since_vco >= CW'(SETTLE_CYC)));
endmodule

bind clkpd_seq clkpd_seq_chk #(.NUM_GRP(NUM_GRP), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk      (ref_clk),
  .rst_n    (rst_n),
  .pd_req   (pd_req),
  .gate_en  (gate_en),
  .parked_s (parked_s),
  .vco_en   (vco_en),
  .xtal_en  (xtal_en),
  .pd_status(pd_status)
);

// File: tb/clkpd_seq_tb_top.sv
`timescale 1ns/1ps
module clkpd_seq_tb_top;
  localparam int TREF_NS = 70;
  localparam int NG      = 4;
  localparam int SETTLE  = 40;
  localparam int HALF_NS [NG] = '{150, 5, 8, 11};

  typedef struct packed {
    int hold;
    int exp_off;
  } vec_t;
  // hold 0 means a sub-cycle glitch between two ref_clk rising edges
  localparam vec_t VEC [4] = '{'{0, 0}, '{3, 1}, '{400, 1}, '{120, 1}};

  logic ref_clk = 1'b0;
  logic rst_n, pd_n;
  logic [NG-1:0] grp_clk, grp_out;
  logic vco_en, xtal_en, pd_status;
  bit rst_done = 1'b0;

  int n_chk = 0, n_fail = 0, off_cnt = 0;
  int xo_bad = 0, xo_seen = 0, xi_bad = 0, xi_seen = 0;
  realtime t_vf = 0, t_xr = 0;

  logic [NG-1:0][15:0] rise_w, pwb_w, pkb_w, pks_w, stb_w, sts_w;

  initial forever #(TREF_NS / 2) ref_clk = ~ref_clk;

  clkpd_seq #(.NUM_GRP(NG), .SETTLE_CYC(SETTLE)) dut_i (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .grp_clk  (grp_clk),
    .grp_out  (grp_out),
    .vco_en   (vco_en),
    .xtal_en  (xtal_en),
    .pd_status(pd_status)
  );

  for (genvar g = 0; g < NG; g++) begin : grp
    logic ck = 1'b0;
    realtime t_rise = 0, t_fall = 0, t_vco = 0, t_chk = 0;
    int rises = 0, pw_bad = 0, park_bad = 0, park_seen = 0, set_bad = 0, set_seen = 0;

    initial forever #(HALF_NS[g]) ck = ~ck;
    assign grp_clk[g] = ck;

    always @(posedge grp_out[g]) begin
      rises++;
      t_rise = $realtime;
      if (t_vco > t_chk) begin
        set_seen++;
        if ($realtime - t_vco < real'(SETTLE * TREF_NS)) set_bad++;
        t_chk = $realtime;
      end
    end
    always @(negedge grp_out[g]) begin
      if (rst_done && ($realtime - t_rise) < real'(HALF_NS[g]) - 0.01) pw_bad++;
      t_fall = $realtime;
    end
    always @(posedge vco_en) if (rst_done) t_vco = $realtime;
    always @(negedge vco_en) if (rst_done) begin
      park_seen++;
      if (grp_out[g] !== 1'b0 || ($realtime - t_fall) < real'(2 * TREF_NS)) park_bad++;
    end

    assign rise_w[g] = 16'(rises);
    assign pwb_w[g]  = 16'(pw_bad);
    assign pkb_w[g]  = 16'(park_bad);
    assign pks_w[g]  = 16'(park_seen);
    assign stb_w[g]  = 16'(set_bad);
    assign sts_w[g]  = 16'(set_seen);
  end

  always @(posedge pd_status) off_cnt++;
  always @(negedge vco_en) t_vf = $realtime;
  always @(posedge xtal_en) t_xr = $realtime;
  always @(negedge xtal_en) if (rst_done) begin
    realtime d;
    d = $realtime - t_vf - real'(TREF_NS);
    xo_seen++;
    if (vco_en !== 1'b0 || d > 0.5 || d < -0.5) xo_bad++;
  end
  always @(posedge vco_en) if (rst_done) begin
    realtime d;
    d = $realtime - t_xr - real'(TREF_NS);
    xi_seen++;
    if (xtal_en !== 1'b1 || d > 0.5 || d < -0.5) xi_bad++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check_running(input string req);
    logic [NG-1:0][15:0] r0;
    r0 = rise_w;
    wait_ref(40);
    for (int g = 0; g < NG; g++)
      chk(rise_w[g] != r0[g], req, $sformatf("group %0d toggles", g), int'(rise_w[g] - r0[g]), 1);
  endtask

  task automatic check_stopped(input string req);
    logic [NG-1:0][15:0] r0;
    r0 = rise_w;
    wait_ref(10);
    chk(rise_w == r0 && grp_out == '0, req, "outputs held low", int'(grp_out), 0);
  endtask

  initial begin
    #(150000 * TREF_NS);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int off0;
    string rq;
    pd_n  = 1'b1;
    rst_n = 1'b0;
    wait_ref(4);
    // R9 reset state
    chk(grp_out == '0, "R9", "outputs low in reset", int'(grp_out), 0);
    chk(vco_en == 1'b1 && xtal_en == 1'b1, "R9", "enables high in reset", int'({vco_en, xtal_en}), 3);
    chk(pd_status == 1'b0, "R9", "status low in reset", int'(pd_status), 0);
    @(negedge ref_clk);
    rst_n    = 1'b1;
    rst_done = 1'b1;
    wait_ref(60);
    check_running("R9");

    for (int i = 0; i < 4; i++) begin
      off0 = off_cnt;
      rq = (VEC[i].exp_off == 0) ? "R1" : ((VEC[i].hold < 10) ? "R6" : "R5");
      if (VEC[i].hold == 0) begin
        @(posedge ref_clk);
        #20 pd_n = 1'b0;
        #10 pd_n = 1'b1;
        wait_ref(20);
        chk(vco_en == 1'b1, "R1", "glitch leaves VCO on", int'(vco_en), 1);
      end else begin
        @(negedge ref_clk);
        pd_n = 1'b0;
        if (VEC[i].hold >= 100) begin
          wait_ref(VEC[i].hold - 12);
          check_stopped("R2");
          chk(pd_status == 1'b1 && vco_en == 1'b0 && xtal_en == 1'b0, "R5", "off state",
              int'({pd_status, vco_en, xtal_en}), 4);
        end else begin
          wait_ref(VEC[i].hold);
        end
        pd_n = 1'b1;
        wait_ref(600);
      end
      chk(off_cnt - off0 == VEC[i].exp_off, rq, "off entries", off_cnt - off0, VEC[i].exp_off);
      chk(pd_status == 1'b0 && vco_en && xtal_en, "R5", "running after release",
          int'({pd_status, vco_en, xtal_en}), 3);
      check_running(rq);
    end

    // R10: request returns while the VCO is settling
    off0 = off_cnt;
    @(negedge ref_clk);
    pd_n = 1'b0;
    wait_ref(150);
    pd_n = 1'b1;
    wait_ref(12);
    begin
      logic [15:0] r1;
      r1 = rise_w[1];
      pd_n = 1'b0;
      wait_ref(200);
      chk(rise_w[1] != r1, "R10", "outputs restarted before re-entry", int'(rise_w[1] - r1), 1);
    end
    chk(pd_status == 1'b1, "R10", "re-entered off", int'(pd_status), 1);
    pd_n = 1'b1;
    wait_ref(600);
    chk(off_cnt - off0 == 2, "R10", "off entries", off_cnt - off0, 2);
    check_running("R10");

    for (int g = 0; g < NG; g++) begin
      chk(pwb_w[g] == 0, "R2", $sformatf("group %0d short pulses", g), int'(pwb_w[g]), 0);
      chk(pkb_w[g] == 0 && pks_w[g] != 0, "R3", $sformatf("group %0d parked before VCO off", g),
          int'(pkb_w[g]), 0);
      chk(stb_w[g] == 0 && sts_w[g] != 0, "R8", $sformatf("group %0d settle window", g),
          int'(stb_w[g]), 0);
    end
    chk(xo_bad == 0 && xo_seen != 0, "R4", "oscillator off one cycle after VCO", xo_bad, 0);
    chk(xi_bad == 0 && xi_seen != 0, "R7", "VCO on one cycle after oscillator", xi_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule